// File: doc/BRIEF.md
# Wormhole Router Input Port Controller

This block is the receive side of one port of a five-port wormhole mesh router. Flits from the upstream neighbour arrive on two channels: a narrow channel for header flits and a wide channel for body and tail flits. Each channel feeds its own queue of equal depth. While either queue is full, a single flow-control line tells the upstream router to stop sending.

A small controller takes the oldest header and asks the switch allocator for that header's output port. At the same time it works out, in dimension order, the output port the packet will need at the next router. When the allocator grants, the controller writes that next-hop port into the header and zero-extends the header to body width. It then drives the header onto the shared switch path, marked by a header strobe. It keeps requesting the same output and forwards body flits one per granted cycle, each marked by a body strobe. The flit whose type code marks a tail closes the packet.

The allocator and the crossbar are outside the block. They appear only as the request, grant and switch-data ports.

Top module: `wh_inport`

## Requirements
- R1: The header queue stores 11-bit flits and the body queue stores 16-bit flits. Each holds 8 entries, and each delivers its flits in arrival order.
- R2: `flow_on` is low in every cycle where either queue holds 8 flits, and high otherwise.
- R3: A flit written to a queue that already holds 8 entries is discarded. It never appears at the switch output, and the queue contents are unchanged.
- R4: The controller starts idle with `req_vld` low. In the cycle after a header is present in the queue, `req_vld` is high and `req_port` equals header bits [6:4]. Port codes are 0 local, 1 north, 2 east, 3 south, 4 west.
- R5: The next-hop route is computed in X-then-Y order, with header bits [10:9] as destination X and [8:7] as destination Y. The next node is this node (`MY_X`,`MY_Y`) moved one step toward the current port: east is x+1, west is x-1, north is y+1, south is y-1. The route is east or west while the X values differ. Otherwise it is north or south while the Y values differ. Otherwise it is local. A current port of local gives local.
- R6: One cycle after a grant in the routing state, `sw_hdr_vld` is high. `sw_data` then holds the header with bits [6:4] replaced by the R5 route, the other header bits unchanged, and bits [15:11] zero.
- R7: While `grant` is low, no flit leaves the block and `req_vld` stays high.
- R8: After the header, `req_port` holds its value. Each cycle with a grant and a queued body flit emits that flit unchanged, with `sw_body_vld` high. Only the type code 11 in bits [15:14] ends the packet. After that flit, `req_vld` drops and the next header is served.
- R9: With the grant held high, a header, body and tail written on three consecutive edges produce the tail at the switch output on the fourth rising edge after the edge that stored the header.
- R10: `sw_hdr_vld` and `sw_body_vld` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hdr_in_vld | input | 1 | Header channel write strobe |
| hdr_in | input | 11 | Header flit |
| body_in_vld | input | 1 | Body channel write strobe |
| body_in | input | 16 | Body or tail flit, type code in [15:14] |
| flow_on | output | 1 | High when the upstream router may send |
| req_vld | output | 1 | Request to the switch allocator |
| req_port | output | 3 | Requested output port |
| grant | input | 1 | Allocator grant for this input |
| sw_data | output | 16 | Flit into the crossbar |
| sw_hdr_vld | output | 1 | `sw_data` carries a padded header |
| sw_body_vld | output | 1 | `sw_data` carries a body or tail flit |

## Verification
The assertions assume the following about the inputs:
- The allocator grant only matters while a request is raised.
- Every header is followed on the body channel by its own body flits, ending in exactly one tail.
- No packet is interleaved with another.

The stimulus keeps to these assumptions. It writes flits as whole packets and holds the grant high or toggles it freely, since the block ignores the grant when it is idle. The one deliberate break of the upstream contract is writing into full queues. That case is limited to the overflow test, where the bench checks that the extra flits leave no trace at the output.

// File: rtl/wh_pkg.sv
package wh_pkg;
  localparam int HDR_W  = 11;
  localparam int BODY_W = 16;
  localparam int CRD_W  = 2;
  localparam int RT_W   = 3;
  localparam int HDR_DX_LSB = 9;
  localparam int HDR_DY_LSB = 7;
  localparam int HDR_RT_LSB = 4;

  localparam logic [RT_W-1:0] PORT_LOCAL = 3'd0;
  localparam logic [RT_W-1:0] PORT_NORTH = 3'd1;
  localparam logic [RT_W-1:0] PORT_EAST  = 3'd2;
  localparam logic [RT_W-1:0] PORT_SOUTH = 3'd3;
  localparam logic [RT_W-1:0] PORT_WEST  = 3'd4;

  localparam logic [1:0] KIND_TAIL = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_ROUTE, ST_FWD} ctrl_st_e;

  function automatic logic is_tail(input logic [BODY_W-1:0] f);
    return f[BODY_W-1 -: 2] == KIND_TAIL;
  endfunction
endpackage

// File: rtl/wh_flit_fifo.sv
module wh_flit_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(full) && $past(wr_en) && !$past(rd_en)) |-> (cnt == $past(cnt)));
endmodule

// File: rtl/wh_xy_lookahead.sv
module wh_xy_lookahead
  import wh_pkg::*;
#(
  parameter int MY_X = 1,
  parameter int MY_Y = 2
) (
  input  logic [CRD_W-1:0] dst_x,
  input  logic [CRD_W-1:0] dst_y,
  input  logic [RT_W-1:0]  cur_rt,
  output logic [RT_W-1:0]  nxt_rt
);
  logic [CRD_W-1:0] hop_x, hop_y;

  always_comb begin
    hop_x = CRD_W'(MY_X);
    hop_y = CRD_W'(MY_Y);
    case (cur_rt)
      PORT_EAST:  hop_x = CRD_W'(MY_X) + CRD_W'(1);
      PORT_WEST:  hop_x = CRD_W'(MY_X) - CRD_W'(1);
      PORT_NORTH: hop_y = CRD_W'(MY_Y) + CRD_W'(1);
      PORT_SOUTH: hop_y = CRD_W'(MY_Y) - CRD_W'(1);
      default: ;
    endcase
  end

  always_comb begin
    if (cur_rt == PORT_LOCAL || cur_rt > PORT_WEST) nxt_rt = PORT_LOCAL;
    else if (dst_x > hop_x)                          nxt_rt = PORT_EAST;
    else if (dst_x < hop_x)                          nxt_rt = PORT_WEST;
    else if (dst_y > hop_y)                          nxt_rt = PORT_NORTH;
    else if (dst_y < hop_y)                          nxt_rt = PORT_SOUTH;
    else                                             nxt_rt = PORT_LOCAL;
  end
endmodule

// File: rtl/wh_inport_ctrl.sv
module wh_inport_ctrl
  import wh_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [HDR_W-1:0]  hdr_head,
  input  logic              hdr_empty,
  input  logic [BODY_W-1:0] body_head,
  input  logic              body_empty,
  input  logic [RT_W-1:0]   nxt_rt,
  input  logic              grant,
  output logic              hdr_pop,
  output logic              body_pop,
  output logic              req_vld,
  output logic [RT_W-1:0]   req_port,
  output logic [BODY_W-1:0] sw_data,
  output logic              sw_hdr_vld,
  output logic              sw_body_vld
);
  ctrl_st_e          st;
  logic [RT_W-1:0]   route_q;
  logic [HDR_W-1:0]  hdr_new;
  logic              tail_out;

  assign req_vld  = (st != ST_IDLE);
  assign req_port = route_q;
  assign hdr_pop  = (st == ST_ROUTE) && grant;
  assign body_pop = (st == ST_FWD) && grant && !body_empty;
  assign tail_out = body_pop && is_tail(body_head);

  always_comb begin
    hdr_new = hdr_head;
    hdr_new[HDR_RT_LSB +: RT_W] = nxt_rt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      route_q     <= PORT_LOCAL;
      sw_data     <= '0;
      sw_hdr_vld  <= 1'b0;
      sw_body_vld <= 1'b0;
    end else begin
      sw_hdr_vld  <= hdr_pop;
      sw_body_vld <= body_pop;
      if (hdr_pop)       sw_data <= BODY_W'(hdr_new);
      else if (body_pop) sw_data <= body_head;
      case (st)
        ST_IDLE: if (!hdr_empty) begin
          st      <= ST_ROUTE;
          route_q <= hdr_head[HDR_RT_LSB +: RT_W];
        end
        ST_ROUTE: if (hdr_pop)  st <= ST_FWD;
        ST_FWD:   if (tail_out) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // R4
  req_after_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(st == ST_IDLE) && !$past(hdr_empty)) |-> req_vld);

  // R6
  hdr_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    sw_hdr_vld |-> $past(req_vld && grant));

  // R7
  no_grant_no_out_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(grant) |-> !(sw_hdr_vld || sw_body_vld));

  // R8
  route_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && $past(req_vld)) |-> $stable(req_port));

  // R8
  tail_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_body_vld && is_tail(sw_data)) |-> !req_vld);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sw_hdr_vld, sw_body_vld}));
endmodule

// File: rtl/wh_inport.sv
module wh_inport
  import wh_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int MY_X  = 1,
  parameter int MY_Y  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_in_vld,
  input  logic [HDR_W-1:0]  hdr_in,
  input  logic              body_in_vld,
  input  logic [BODY_W-1:0] body_in,
  output logic              flow_on,
  output logic              req_vld,
  output logic [RT_W-1:0]   req_port,
  input  logic              grant,
  output logic [BODY_W-1:0] sw_data,
  output logic              sw_hdr_vld,
  output logic              sw_body_vld
);
  logic [HDR_W-1:0]  hdr_head;
  logic [BODY_W-1:0] body_head;
  logic              hdr_full, hdr_empty, body_full, body_empty;
  logic              hdr_pop, body_pop;
  logic [RT_W-1:0]   nxt_rt;

  wh_flit_fifo #(.W(HDR_W), .DEPTH(DEPTH)) u_hdr_q (
    .clk(clk), .rst(rst), .wr_en(hdr_in_vld), .wr_data(hdr_in),
    .rd_en(hdr_pop), .head(hdr_head), .full(hdr_full), .empty(hdr_empty));

  wh_flit_fifo #(.W(BODY_W), .DEPTH(DEPTH)) u_body_q (
    .clk(clk), .rst(rst), .wr_en(body_in_vld), .wr_data(body_in),
    .rd_en(body_pop), .head(body_head), .full(body_full), .empty(body_empty));

  wh_xy_lookahead #(.MY_X(MY_X), .MY_Y(MY_Y)) u_rc (
    .dst_x(hdr_head[HDR_DX_LSB +: CRD_W]),
    .dst_y(hdr_head[HDR_DY_LSB +: CRD_W]),
    .cur_rt(hdr_head[HDR_RT_LSB +: RT_W]),
    .nxt_rt(nxt_rt));

  wh_inport_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .hdr_head(hdr_head), .hdr_empty(hdr_empty),
    .body_head(body_head), .body_empty(body_empty),
    .nxt_rt(nxt_rt), .grant(grant),
    .hdr_pop(hdr_pop), .body_pop(body_pop),
    .req_vld(req_vld), .req_port(req_port),
    .sw_data(sw_data), .sw_hdr_vld(sw_hdr_vld), .sw_body_vld(sw_body_vld));

  assign flow_on = !(hdr_full || body_full);

  // R2
  flow_vs_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(flow_on) && !$past(hdr_pop) && !$past(body_pop)
     && !$past(rst)) |-> !flow_on);
endmodule

// File: tb/test_wh_inport.sv
module test_wh_inport;
  localparam int MYX = 1;
  localparam int MYY = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        hdr_in_vld;
  logic [10:0] hdr_in;
  logic        body_in_vld;
  logic [15:0] body_in;
  logic        flow_on;
  logic        req_vld;
  logic [2:0]  req_port;
  logic        grant;
  logic [15:0] sw_data;
  logic        sw_hdr_vld;
  logic        sw_body_vld;

  int checks = 0;
  int errors = 0;

  logic [15:0] exp_d [256];
  bit          exp_h [256];
  int          ew = 0;
  int          er = 0;

  always #5 clk = ~clk;

  wh_inport #(.DEPTH(8), .MY_X(MYX), .MY_Y(MYY)) i_wh_inport (
    .clk(clk), .rst(rst), .hdr_in_vld(hdr_in_vld), .hdr_in(hdr_in),
    .body_in_vld(body_in_vld), .body_in(body_in), .flow_on(flow_on),
    .req_vld(req_vld), .req_port(req_port), .grant(grant),
    .sw_data(sw_data), .sw_hdr_vld(sw_hdr_vld), .sw_body_vld(sw_body_vld));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [2:0] exp_route(input int dx, input int dy, input int rt);
    int hx = MYX;
    int hy = MYY;
    if (rt == 0 || rt > 4) return 3'd0;
    if (rt == 2) hx = hx + 1;
    if (rt == 4) hx = hx - 1;
    if (rt == 1) hy = hy + 1;
    if (rt == 3) hy = hy - 1;
    if (dx != hx) return (dx > hx) ? 3'd2 : 3'd4;
    if (dy != hy) return (dy > hy) ? 3'd1 : 3'd3;
    return 3'd0;
  endfunction

  function automatic logic [10:0] mk_hdr(input int dx, input int dy, input int rt, input int sp);
    return {2'(dx), 2'(dy), 3'(rt), 3'(sp), 1'b1};
  endfunction

  function automatic logic [15:0] padded(input logic [10:0] h);
    logic [10:0] n = h;
    n[6:4] = exp_route(int'(h[10:9]), int'(h[8:7]), int'(h[6:4]));
    return {5'b0, n};
  endfunction

  task automatic expect_flit(input logic [15:0] d, input bit is_hdr);
    exp_d[ew] = d;
    exp_h[ew] = is_hdr;
    ew++;
  endtask

  // Output monitor: every strobe must match the next expected flit (R1, R6, R8, R10)
  always @(negedge clk) begin
    if (!rst && (sw_hdr_vld || sw_body_vld)) begin
      if (er >= ew) begin
        chk(1'b0, "R3 unexpected flit", {16'h0, sw_data}, 32'h0);
      end else begin
        chk(!(sw_hdr_vld && sw_body_vld), "R10 both strobes", 32'h3, 32'h1);
        chk(sw_hdr_vld == exp_h[er], "R6 strobe kind", 32'(sw_hdr_vld), 32'(exp_h[er]));
        chk(sw_data == exp_d[er], exp_h[er] ? "R6 header data" : "R8 body data",
            32'(sw_data), 32'(exp_d[er]));
        er++;
      end
    end
  end

  task automatic send_basic(input int dx, input int dy, input int rt, input int pl);
    logic [10:0] h = mk_hdr(dx, dy, rt, dx + dy);
    @(negedge clk);
    hdr_in_vld = 1'b1; hdr_in = h;
    expect_flit(padded(h), 1'b1);
    @(negedge clk);
    hdr_in_vld = 1'b0;
    body_in_vld = 1'b1; body_in = {2'b11, 14'(pl)};
    expect_flit({2'b11, 14'(pl)}, 1'b0);
    @(negedge clk);
    body_in_vld = 1'b0;
    chk(req_vld && req_port == 3'(rt), "R4 request port", {req_vld, 3'(req_port)},
        {1'b1, 3'(rt)});
    repeat (3) @(negedge clk);
    chk(!req_vld, "R8 idle after tail", 32'(req_vld), 32'h0);
  endtask

  initial begin
    #200000ns;
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; hdr_in_vld = 1'b0; hdr_in = '0; body_in_vld = 1'b0;
    body_in = '0; grant = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(flow_on && !req_vld && !sw_hdr_vld && !sw_body_vld, "R2 reset state",
        {flow_on, req_vld, sw_hdr_vld, sw_body_vld}, 32'h8);

    // R5 R6 R4: sweep every destination and every current-route code
    grant = 1'b1;
    for (int dx = 0; dx < 4; dx++)
      for (int dy = 0; dy < 4; dy++)
        for (int rt = 0; rt < 5; rt++)
          send_basic(dx, dy, rt, dx * 64 + dy * 8 + rt);
    chk(er == ew, "R5 sweep consumed", 32'(er), 32'(ew));

    // R7: stall with grant low
    grant = 1'b0;
    @(negedge clk);
    hdr_in_vld = 1'b1; hdr_in = mk_hdr(3, 0, 2, 5);
    expect_flit(padded(mk_hdr(3, 0, 2, 5)), 1'b1);
    @(negedge clk);
    hdr_in_vld = 1'b0; body_in_vld = 1'b1; body_in = 16'hC0DE;
    expect_flit(16'hC0DE, 1'b0);
    @(negedge clk);
    body_in_vld = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk(req_vld && !sw_hdr_vld && !sw_body_vld, "R7 hold without grant",
          {req_vld, sw_hdr_vld, sw_body_vld}, 32'h4);
      @(negedge clk);
    end
    grant = 1'b1;
    repeat (4) @(negedge clk);
    chk(!req_vld && er == ew, "R7 release after grant", 32'(er), 32'(ew));

    // R8: several bodies with gaps, grant toggling, non-tail type codes
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      grant = (k % 3 != 1) || (k > 12);
      hdr_in_vld = 1'b0; body_in_vld = 1'b0;
      if (k == 0) begin
        hdr_in_vld = 1'b1; hdr_in = mk_hdr(0, 3, 4, 2);
        expect_flit(padded(mk_hdr(0, 3, 4, 2)), 1'b1);
      end else if (k == 2 || k == 3 || k == 6 || k == 7) begin
        body_in_vld = 1'b1;
        body_in = (k == 3) ? 16'h8123 : (k == 6) ? 16'h0456 : {2'b01, 14'(k)};
        expect_flit(body_in, 1'b0);
      end else if (k == 9) begin
        body_in_vld = 1'b1; body_in = 16'hFACE;
        expect_flit(16'hFACE, 1'b0);
      end
    end
    chk(!req_vld && er == ew, "R8 multi-body packet done", 32'(er), 32'(ew));

    // R9: header, body, tail on consecutive edges
    grant = 1'b1;
    @(negedge clk);
    hdr_in_vld = 1'b1; hdr_in = mk_hdr(2, 2, 2, 0);
    expect_flit(padded(mk_hdr(2, 2, 2, 0)), 1'b1);
    @(negedge clk);
    hdr_in_vld = 1'b0; body_in_vld = 1'b1; body_in = 16'h4111;
    expect_flit(16'h4111, 1'b0);
    @(negedge clk);
    body_in = 16'hC222;
    expect_flit(16'hC222, 1'b0);
    @(negedge clk);
    body_in_vld = 1'b0;
    @(negedge clk);
    chk(sw_body_vld && sw_data == 16'h4111, "R9 body slot", 32'(sw_data), 32'h4111);
    @(negedge clk);
    chk(sw_body_vld && sw_data == 16'hC222, "R9 tail on fourth edge", 32'(sw_data), 32'hC222);

    // R2 R3 R1: fill both queues, overflow them, then drain
    grant = 1'b0;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      hdr_in_vld = 1'b1; hdr_in = mk_hdr(k % 4, 3 - (k % 4), 1, k % 8);
      @(negedge clk);
      hdr_in_vld = 1'b0;
      chk(flow_on == (k < 7), "R2 flow vs header fill", 32'(flow_on), 32'(k < 7));
    end
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      body_in_vld = 1'b1; body_in = {2'b11, 14'(16'h100 + k)};
    end
    @(negedge clk);
    body_in_vld = 1'b0;
    chk(!flow_on, "R2 flow off when full", 32'(flow_on), 32'h0);
    for (int k = 0; k < 8; k++) begin
      expect_flit(padded(mk_hdr(k % 4, 3 - (k % 4), 1, k % 8)), 1'b1);
      expect_flit({2'b11, 14'(16'h100 + k)}, 1'b0);
    end
    grant = 1'b1;
    repeat (30) @(negedge clk);
    chk(flow_on, "R2 flow back on", 32'(flow_on), 32'h1);
    chk(!req_vld && er == ew, "R3 ninth flits discarded R1 order", 32'(er), 32'(ew));
    send_basic(1, 1, 0, 16'h2AA);
    chk(er == ew, "R3 no leftover flit", 32'(er), 32'(ew));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule